// File: doc/BRIEF.md
# Block-Ack Window Tracker

This block keeps the per-frame bookkeeping for one transmit queue that runs under block acknowledgement. It follows a sliding window of at most 64 consecutive 12-bit sequence numbers. For every slot in that window it holds three bits: whether the frame went out, whether the receiver confirmed it, and whether it is waiting to be sent again. A transmit path offers new frames by sequence number. The tracker admits a frame only when the window size and the outstanding-frame limit allow it.

A block-ack report carries a starting sequence number and a 64-bit bitmap. Bit i of the bitmap refers to sequence start+i, modulo 4096. Confirmed frames are marked as done. Frames that went out, are covered by the report and are still unconfirmed are queued for resending, and the block announces them one per cycle. The window start then slides over the run of confirmed slots at its low end, and the slots it passes are freed. Confirmations can arrive in any order. The start moves only when the oldest slot is confirmed.

Top module: `ba_window_tracker`

## Requirements
- R1: After a synchronous active-high reset the window start is 0, no slot is marked, and `retx_valid` is low.
- R2: `send_accept` is high exactly when `send_valid` is high and all of the following hold. The offset (send_seq - win_start) mod 4096 is below min(cfg_win_size, 64). That slot is not already marked sent. The count of sent-but-unconfirmed slots is below min(cfg_frame_limit, 64). An accepted frame marks its slot as sent at the clock edge.
- R3: On `ba_valid`, bitmap bit i applies to sequence (ba_ssn + i) mod 4096. A set bit marks a sent slot inside the window as confirmed at that clock edge.
- R4: Bitmap bits that land on a slot at or beyond min(cfg_win_size, 64), or on a slot never sent, change nothing.
- R5: A sent, unconfirmed slot that a report covers with a zero bit becomes pending for resend.
- R6: While any slot is pending, `retx_valid` is high and `retx_seq` gives the pending slot at the lowest offset. That slot stops being pending after that cycle, so each request appears once.
- R7: One cycle after the confirmed slots form a contiguous run starting at offset 0, the window start has advanced by the length of that run. The freed slots read as unsent and unconfirmed, so a later send to them is accepted.
- R8: While the slot at offset 0 is unconfirmed, the window start does not move, even if later slots are confirmed (completion out of order).
- R9: The window start and all offsets wrap modulo 4096.
- R10: A confirmed slot is never pending. A confirmation that arrives after a resend request cancels any resend not yet announced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_win_size | input | 7 | Window size in slots, values above 64 act as 64 |
| cfg_frame_limit | input | 7 | Maximum sent-but-unconfirmed frames, values above 64 act as 64 |
| send_valid | input | 1 | A frame is offered for transmission |
| send_seq | input | 12 | Sequence number of the offered frame |
| send_accept | output | 1 | The offered frame is admitted this cycle |
| ba_valid | input | 1 | A block-ack report is present |
| ba_ssn | input | 12 | Starting sequence of the report |
| ba_bitmap | input | 64 | Confirmation bits, bit i for ba_ssn+i |
| retx_valid | output | 1 | A resend request is present |
| retx_seq | output | 12 | Sequence number to resend |
| win_start | output | 12 | Current window start sequence |

## Verification
Wrong state shows up at the ports within a few cycles. A lost sent bit makes a repeated send of the same sequence accepted in the very next cycle. A stray confirmed bit moves `win_start` one cycle after it is set. A pending bit that is lost or duplicated shows in the `retx_valid`/`retx_seq` stream, which is drained one request per cycle. The bench therefore compares all four outputs every cycle against a model driven only by the requirements. It adds directed sequences for out-of-order confirmation, cancellation and the modulo-4096 wrap.

// File: rtl/ba_win_pkg.sv
package ba_win_pkg;
    localparam int SEQ_W = 12;
    localparam int SLOTS = 64;
    localparam int CFG_W = 7;
    localparam int IDX_W = $clog2(SLOTS);

    typedef logic [SEQ_W-1:0] seq_t;

    // Per-slot state, bit k is the slot at offset k from the window start
    typedef struct packed {
        logic [SLOTS-1:0] sent;
        logic [SLOTS-1:0] acked;
        logic [SLOTS-1:0] pend;
    } slot_map_t;

    function automatic seq_t seq_offset(seq_t a, seq_t base);
        return a - base;
    endfunction

    function automatic logic [CFG_W-1:0] clamp_cfg(logic [CFG_W-1:0] v);
        return (v > CFG_W'(SLOTS)) ? CFG_W'(SLOTS) : v;
    endfunction
endpackage

// File: rtl/ba_first_set.sv
module ba_first_set #(
    parameter int N = 64,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  vec,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/ba_report_merge.sv
module ba_report_merge #(
    parameter int SLOTS = 64,
    parameter int SEQ_W = 12,
    parameter int CFG_W = 7,
    localparam int IDX_W = $clog2(SLOTS)
) (
    input  logic             ba_valid,
    input  logic [SEQ_W-1:0] ba_ssn,
    input  logic [SLOTS-1:0] ba_bitmap,
    input  logic [SEQ_W-1:0] win_start,
    input  logic [CFG_W-1:0] win_lim,
    input  logic [SLOTS-1:0] sent,
    input  logic [SLOTS-1:0] acked,
    output logic [SLOTS-1:0] ack_set,
    output logic [SLOTS-1:0] nack_set
);
    for (genvar k = 0; k < SLOTS; k++) begin : g_slot
        logic [SEQ_W-1:0] bit_pos;
        logic             covered;
        logic             hit;
        assign bit_pos = win_start + SEQ_W'(k) - ba_ssn;
        assign covered = ba_valid && (win_lim > CFG_W'(k)) &&
                         (bit_pos < SEQ_W'(SLOTS));
        assign hit      = ba_bitmap[bit_pos[IDX_W-1:0]];
        assign ack_set[k]  = covered & hit & sent[k];
        assign nack_set[k] = covered & ~hit & sent[k] & ~acked[k];
    end
endmodule

// File: rtl/ba_window_tracker.sv
module ba_window_tracker
    import ba_win_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [6:0]  cfg_win_size,
    input  logic [6:0]  cfg_frame_limit,
    input  logic        send_valid,
    input  logic [11:0] send_seq,
    output logic        send_accept,
    input  logic        ba_valid,
    input  logic [11:0] ba_ssn,
    input  logic [63:0] ba_bitmap,
    output logic        retx_valid,
    output logic [11:0] retx_seq,
    output logic [11:0] win_start
);
    slot_map_t        st_q, st_mid, st_d;
    seq_t             start_q;
    logic [CFG_W-1:0] win_lim, lim_frames, outstanding;
    seq_t             send_off;
    logic [SLOTS-1:0] send_hot, retx_clr, ack_set, nack_set;
    logic             pend_found, gap_found;
    logic [IDX_W-1:0] pend_idx, gap_idx;
    logic [CFG_W-1:0] run_len;

    assign win_lim     = clamp_cfg(cfg_win_size);
    assign lim_frames  = clamp_cfg(cfg_frame_limit);
    assign outstanding = CFG_W'($countones(st_q.sent & ~st_q.acked));
    assign send_off    = seq_offset(send_seq, start_q);

    assign send_accept = send_valid && (send_off < SEQ_W'(win_lim)) &&
                         !st_q.sent[send_off[IDX_W-1:0]] &&
                         (outstanding < lim_frames);
    assign send_hot = send_accept ? (SLOTS'(1) << send_off[IDX_W-1:0]) : '0;

    ba_report_merge #(.SLOTS(SLOTS), .SEQ_W(SEQ_W), .CFG_W(CFG_W)) u_merge (
        .ba_valid  (ba_valid),
        .ba_ssn    (ba_ssn),
        .ba_bitmap (ba_bitmap),
        .win_start (start_q),
        .win_lim   (win_lim),
        .sent      (st_q.sent),
        .acked     (st_q.acked),
        .ack_set   (ack_set),
        .nack_set  (nack_set)
    );

    // Lowest pending slot is the next resend request
    ba_first_set #(.N(SLOTS)) u_retx_pick (
        .vec   (st_q.pend),
        .found (pend_found),
        .idx   (pend_idx)
    );

    // First unconfirmed slot bounds the confirmed prefix
    ba_first_set #(.N(SLOTS)) u_gap_scan (
        .vec   (~st_q.acked),
        .found (gap_found),
        .idx   (gap_idx)
    );

    assign run_len  = gap_found ? CFG_W'(gap_idx) : CFG_W'(SLOTS);
    assign retx_clr = pend_found ? (SLOTS'(1) << pend_idx) : '0;

    always_comb begin
        st_mid.sent  = st_q.sent | send_hot;
        st_mid.acked = st_q.acked | ack_set;
        st_mid.pend  = ((st_q.pend & ~retx_clr) | nack_set) & ~ack_set;
        st_d.sent    = st_mid.sent  >> run_len;
        st_d.acked   = st_mid.acked >> run_len;
        st_d.pend    = st_mid.pend  >> run_len;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= '0;
            start_q <= '0;
        end else begin
            st_q    <= st_d;
            start_q <= start_q + SEQ_W'(run_len);
        end
    end

    assign retx_valid = pend_found;
    assign retx_seq   = start_q + SEQ_W'(pend_idx);
    assign win_start  = start_q;

    // R4: confirmation only ever lands on sent slots
    p_ack_needs_send_r4: assert property (@(posedge clk) disable iff (rst)
        (st_q.acked & ~st_q.sent) == '0);

    // R5: resend is only queued for frames that went out
    p_pend_needs_send_r5: assert property (@(posedge clk) disable iff (rst)
        (st_q.pend & ~st_q.sent) == '0);

    // R10: a confirmed slot is never awaiting resend
    p_no_retx_of_acked_r10: assert property (@(posedge clk) disable iff (rst)
        (st_q.pend & st_q.acked) == '0);

    // R8: start is pinned while the oldest slot is unconfirmed
    p_start_holds_r8: assert property (@(posedge clk) disable iff (rst)
        !st_q.acked[0] |=> (start_q == $past(start_q)));

    // R6: a request is not repeated unless a new report re-queues it
    p_retx_once_r6: assert property (@(posedge clk) disable iff (rst)
        (retx_valid && !ba_valid) |=>
        !(retx_valid && retx_seq == $past(retx_seq)));
endmodule

// File: tb/ba_window_tracker_tb.sv
module ba_window_tracker_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [6:0]  cfg_win_size = 7'd64;
    logic [6:0]  cfg_frame_limit = 7'd64;
    logic        send_valid = 1'b0;
    logic [11:0] send_seq = '0;
    logic        send_accept;
    logic        ba_valid = 1'b0;
    logic [11:0] ba_ssn = '0;
    logic [63:0] ba_bitmap = '0;
    logic        retx_valid;
    logic [11:0] retx_seq;
    logic [11:0] win_start;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    logic [63:0] m_sent = '0, m_acked = '0, m_pend = '0;
    logic [11:0] m_start = '0;

    always #4 clk = ~clk;

    ba_window_tracker u_dut (
        .clk(clk), .rst(rst),
        .cfg_win_size(cfg_win_size), .cfg_frame_limit(cfg_frame_limit),
        .send_valid(send_valid), .send_seq(send_seq), .send_accept(send_accept),
        .ba_valid(ba_valid), .ba_ssn(ba_ssn), .ba_bitmap(ba_bitmap),
        .retx_valid(retx_valid), .retx_seq(retx_seq), .win_start(win_start)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: run hung, got %0d cycles exp < 150000", cycles);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0h exp %0h", tag, what, act, exp);
        end
    endtask

    function automatic int clampv(logic [6:0] v);
        return (v > 7'd64) ? 64 : int'(v);
    endfunction

    // One cycle: compare outputs to the model, then advance the model at the edge
    task automatic step(string tag);
        int wl, fl, outst, off, pk, run;
        logic acc;
        logic [63:0] ack, nack, clr, shot;
        #1;
        wl = clampv(cfg_win_size);
        fl = clampv(cfg_frame_limit);
        outst = $countones(m_sent & ~m_acked);
        off = int'(12'(send_seq - m_start));
        acc = send_valid && off < wl && !m_sent[off % 64] && outst < fl;
        ack = '0; nack = '0;
        for (int k = 0; k < 64; k++) begin
            int i;
            i = int'(12'(m_start + 12'(k) - ba_ssn));
            if (ba_valid && k < wl && i < 64 && m_sent[k]) begin
                if (ba_bitmap[i]) ack[k] = 1'b1;
                else if (!m_acked[k]) nack[k] = 1'b1;
            end
        end
        pk = -1;
        for (int k = 63; k >= 0; k--) if (m_pend[k]) pk = k;
        run = 64;
        for (int k = 63; k >= 0; k--) if (!m_acked[k]) run = k;
        chk(tag, "send_accept", 64'(send_accept), 64'(acc));
        chk(tag, "retx_valid", 64'(retx_valid), 64'(pk >= 0));
        if (pk >= 0) chk(tag, "retx_seq", 64'(retx_seq), 64'(12'(m_start + 12'(pk))));
        chk(tag, "win_start", 64'(win_start), 64'(m_start));
        @(posedge clk);
        clr  = (pk >= 0) ? (64'd1 << pk) : '0;
        shot = acc ? (64'd1 << (off % 64)) : '0;
        m_sent  = (m_sent | shot) >> run;
        m_acked = (m_acked | ack) >> run;
        m_pend  = (((m_pend & ~clr) | nack) & ~ack) >> run;
        m_start = m_start + 12'(run);
        @(negedge clk);
        send_valid = 1'b0;
        ba_valid = 1'b0;
    endtask

    task automatic do_send(logic [11:0] s, string tag);
        send_valid = 1'b1; send_seq = s; step(tag);
    endtask

    task automatic do_ba(logic [11:0] s, logic [63:0] bm, string tag);
        ba_valid = 1'b1; ba_ssn = s; ba_bitmap = bm; step(tag);
    endtask

    initial begin
        void'($urandom(32'h5eed_ba11));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        chk("R1", "win_start", 64'(win_start), 64'd0);
        chk("R1", "retx_valid", 64'(retx_valid), 64'd0);

        // R2: admission by offset and by slot occupancy
        for (int s = 0; s < 4; s++) do_send(12'(s), "R2");
        send_valid = 1'b1; send_seq = 12'd64; #1;
        chk("R2", "offset 64 rejected", 64'(send_accept), 64'd0);
        step("R2");
        send_valid = 1'b1; send_seq = 12'd0; #1;
        chk("R2", "resend of sent slot rejected", 64'(send_accept), 64'd0);
        step("R2");

        // R3 R5 R8: out-of-order confirmation of seq 1 only
        do_ba(12'd0, 64'h2, "R3");
        #1;
        chk("R6", "first request lowest", 64'(retx_seq), 64'd0);
        chk("R8", "start pinned", 64'(win_start), 64'd0);
        step("R6");
        #1; chk("R6", "second request", 64'(retx_seq), 64'd2);
        step("R6");
        #1; chk("R5", "third request", 64'(retx_seq), 64'd3);
        step("R6");
        #1; chk("R6", "drained", 64'(retx_valid), 64'd0);
        do_ba(12'd0, 64'hF, "R3");
        step("R7");
        #1; chk("R7", "start after prefix", 64'(win_start), 64'd4);

        // R10: confirmation cancels a queued resend
        do_send(12'd4, "R2"); do_send(12'd5, "R2");
        do_ba(12'd4, 64'h0, "R5");
        do_ba(12'd4, 64'h3, "R10");
        #1; chk("R10", "cancelled resend", 64'(retx_valid), 64'd0);
        step("R10");
        #1; chk("R7", "start after cancel", 64'(win_start), 64'd6);

        // R4: bits outside a window of 2, and on unsent slots
        cfg_win_size = 7'd2;
        do_send(12'd6, "R2"); do_send(12'd7, "R2");
        send_valid = 1'b1; send_seq = 12'd8; #1;
        chk("R2", "beyond window 2", 64'(send_accept), 64'd0);
        step("R2");
        do_ba(12'd6, {64{1'b1}}, "R4");
        step("R4");
        #1; chk("R4", "start stops at 8", 64'(win_start), 64'd8);
        do_ba(12'd100, {64{1'b1}}, "R4");
        do_ba(12'd8, {64{1'b1}}, "R4");
        step("R4"); step("R4");
        #1; chk("R4", "unsent slot ignored", 64'(win_start), 64'd8);
        do_send(12'd8, "R7");
        do_ba(12'd8, 64'h1, "R7");
        step("R7");

        // R2: frame limit of 2
        cfg_win_size = 7'd64; cfg_frame_limit = 7'd2;
        do_send(12'd9, "R2"); do_send(12'd10, "R2");
        send_valid = 1'b1; send_seq = 12'd11; #1;
        chk("R2", "frame limit", 64'(send_accept), 64'd0);
        step("R2");
        do_ba(12'd9, 64'h3, "R2");
        step("R2");
        cfg_frame_limit = 7'd64;

        // R9: full windows until the start wraps
        while (m_start < 12'd4040) begin
            logic [11:0] base;
            base = m_start;
            for (int k = 0; k < 64; k++) do_send(base + 12'(k), "R9");
            do_ba(base, {64{1'b1}}, "R9");
            step("R9");
        end
        begin
            logic [11:0] base;
            base = m_start;
            for (int k = 0; k < 64; k++) do_send(base + 12'(k), "R9");
            do_ba(base, {64{1'b1}}, "R9");
            step("R9");
            #1; chk("R9", "wrapped start", 64'(win_start), 64'(12'(base + 12'd64)));
        end

        // Random traffic against the model
        for (int n = 0; n < 3000; n++) begin
            if ($urandom_range(0, 49) == 0) begin
                cfg_win_size = 7'($urandom_range(1, 70));
                cfg_frame_limit = 7'($urandom_range(1, 70));
            end
            if ($urandom_range(0, 9) < 7) begin
                send_valid = 1'b1;
                send_seq = m_start + 12'($urandom_range(0, 72));
            end
            if ($urandom_range(0, 6) == 0) begin
                ba_valid = 1'b1;
                ba_ssn = m_start + 12'($urandom_range(0, 16)) - 12'd8;
                ba_bitmap = {$urandom, $urandom};
            end
            step("R3");
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule